// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a processor's two-part virtual address into a 24-bit absolute memory address. The two parts are a segment number and a word offset. Software first loads a descriptor base register through a dedicated strobe. That register gives the location of the per-process descriptor array and the number of descriptors in it. For each translation the block reads the two-word descriptor of the addressed segment from memory. It then checks the valid bit, the length bound and the permission for the kind of access.

A descriptor maps its segment in one of two ways. It can map the segment directly as one contiguous region, or it can point to a page table of 1024-word pages. For a paged segment the block also reads the page table word and checks that the page is resident. It then writes the word back with the used bit set, and with the modified bit set as well when the access is a store.

Only one translation is in flight at a time. The response carries either an address or a 3-bit fault code. Memory is reached through one 36-bit read/write port with a valid/ready request handshake. Read data returns on a separate strobe.

Top module: `seg_xlate`

## Requirements
- R1: After reset the descriptor base register is cleared and `req_ready` stays low until `dbr_we` has been pulsed. No memory request is issued in that time.
- R2: A segment number greater than or equal to the loaded descriptor count gets fault code 1. No memory access is made for it.
- R3: The descriptor is read as two words, the first at base + 2·segno and the second at base + 2·segno + 1. Word 0 holds the 24-bit address in bits 35:12 and the valid bit in bit 2. Word 1 holds the 14-bit bound in bits 35:22, read permission in bit 21, execute permission in bit 20, write permission in bit 19 and the unpaged flag in bit 17.
- R4: A descriptor whose valid bit is 0 gets fault code 2.
- R5: An access whose offset divided by 16 is greater than the bound field gets fault code 3.
- R6: Access kind 0 (read) needs the read bit, kind 1 (store) needs the write bit and kind 2 (fetch) needs the execute bit. Kind 3 is always denied. A denied access gets fault code 4.
- R7: With the unpaged flag set, the result is the descriptor address plus the offset, modulo 2^24.
- R8: With the unpaged flag clear, the page table word is read at the descriptor address plus offset/1024. The result is that word's 18-bit frame field (bits 35:18) times 64, plus offset modulo 1024.
- R9: A page table word whose valid bit (bit 9) is 0 gets fault code 5, and no write-back is made.
- R10: A successful paged access writes the page table word back to the same address with the used bit (bit 13) set. A store also sets the modified bit (bit 12). All other bits are unchanged. The write completes before the response.
- R11: When several checks fail, the fault reported is the first failing one in this order: count, valid, bound, permission, page.
- R12: A new request is accepted only after the previous response has been taken. A pending response, and a pending memory request, hold steady until accepted.
- R13: A faulting response carries address 0, and a successful one carries fault code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbr_we | input | 1 | Load strobe for the descriptor base register |
| dbr_base | input | 24 | Absolute address of the descriptor array |
| dbr_len | input | 13 | Number of descriptors in the array |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_segno | input | 12 | Segment number |
| req_offset | input | 18 | Word offset within the segment |
| req_kind | input | 2 | 0 read, 1 store, 2 fetch, 3 reserved |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Result taken |
| rsp_addr | output | 24 | Absolute address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 count, 2 segment, 3 bound, 4 access, 5 page |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 24 | Memory word address |
| mem_req_wdata | output | 36 | Write data |
| mem_rsp_valid | input | 1 | Read data present, at least one cycle after acceptance |
| mem_rsp_rdata | input | 36 | Read data |

## Verification
The bench builds the block with its default parameters: a 12-bit segment number, an 18-bit offset and 1024-word pages. With these settings both the top segment number 4095 and the full 14-bit bound can be reached. The descriptor count is loaded at run time. A small count puts the range fault in reach, a count of 4096 reaches the last descriptor, and a count of zero rejects everything. The memory model stalls its ready signal and varies its read latency, and the bench delays taking responses. Together these exercise every wait state of the sequencer.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_RANGE  = 3'd1,
    FLT_SEG    = 3'd2,
    FLT_BOUND  = 3'd3,
    FLT_ACCESS = 3'd4,
    FLT_PAGE   = 3'd5
  } fault_e;

  // descriptor word 0
  localparam int SDW_ADDR_LSB  = 12;
  localparam int SDW_VALID_BIT = 2;
  // descriptor word 1
  localparam int BOUND_W       = 14;
  localparam int SDW_BOUND_LSB = 22;
  localparam int SDW_RD_BIT    = 21;
  localparam int SDW_EX_BIT    = 20;
  localparam int SDW_WR_BIT    = 19;
  localparam int SDW_UNP_BIT   = 17;
  // page table word
  localparam int FRAME_W       = 18;
  localparam int PTW_FRAME_LSB = 18;
  localparam int PTW_USED_BIT  = 13;
  localparam int PTW_MOD_BIT   = 12;
  localparam int PTW_VALID_BIT = 9;

  typedef struct packed {
    logic [BOUND_W-1:0] bound;
    logic               rd;
    logic               ex;
    logic               wr;
    logic               unpaged;
  } sdw_attr_t;

endpackage

// File: rtl/seg_xlate_sdw_chk.sv
module seg_xlate_sdw_chk
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W  = 18,
  parameter int PG_W   = 10,
  parameter int BLK_W  = 4,
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] seg_base,
  input  logic              seg_valid,
  input  sdw_attr_t         attr,
  input  logic [OFF_W-1:0]  offset,
  input  acc_kind_e         kind,
  output fault_e            fault,
  output logic              unpaged,
  output logic [ADDR_W-1:0] next_addr
);

  localparam int BLKIDX_W = OFF_W - BLK_W;
  localparam int PGIDX_W  = OFF_W - PG_W;
  localparam int CMP_W    = (BLKIDX_W > BOUND_W) ? BLKIDX_W : BOUND_W;

  logic [BLKIDX_W-1:0] blk_idx;
  logic [PGIDX_W-1:0]  pg_idx;
  logic                bound_bad;
  logic                perm_ok;

  assign blk_idx   = offset[OFF_W-1:BLK_W];
  assign pg_idx    = offset[OFF_W-1:PG_W];
  assign bound_bad = CMP_W'(blk_idx) > CMP_W'(attr.bound);
  assign unpaged   = attr.unpaged;

  always_comb begin
    unique case (kind)
      ACC_READ:  perm_ok = attr.rd;
      ACC_STORE: perm_ok = attr.wr;
      ACC_FETCH: perm_ok = attr.ex;
      default:   perm_ok = 1'b0;
    endcase
  end

  // first failing check wins
  always_comb begin
    if (!seg_valid)    fault = FLT_SEG;
    else if (bound_bad) fault = FLT_BOUND;
    else if (!perm_ok)  fault = FLT_ACCESS;
    else                fault = FLT_NONE;
  end

  always_comb begin
    if (attr.unpaged) next_addr = seg_base + ADDR_W'(offset);
    else              next_addr = seg_base + ADDR_W'(pg_idx);
  end

endmodule

// File: rtl/seg_xlate_ptw_unit.sv
module seg_xlate_ptw_unit
  import seg_xlate_pkg::*;
#(
  parameter int PG_W   = 10,
  parameter int ADDR_W = 24,
  parameter int WORD_W = 36
) (
  input  logic [WORD_W-1:0] ptw,
  input  logic [PG_W-1:0]   pg_off,
  input  logic              store,
  output logic              page_ok,
  output logic [WORD_W-1:0] ptw_upd,
  output logic [ADDR_W-1:0] abs_addr
);

  localparam int SHIFT = ADDR_W - FRAME_W;

  logic [FRAME_W-1:0] frame;

  assign frame    = ptw[PTW_FRAME_LSB +: FRAME_W];
  assign page_ok  = ptw[PTW_VALID_BIT];
  assign abs_addr = {frame, {SHIFT{1'b0}}} + ADDR_W'(pg_off);

  always_comb begin
    ptw_upd = ptw;
    ptw_upd[PTW_USED_BIT] = 1'b1;
    if (store) ptw_upd[PTW_MOD_BIT] = 1'b1;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 12,
  parameter int OFF_W  = 18,
  parameter int PG_W   = 10,
  parameter int BLK_W  = 4,
  parameter int ADDR_W = 24,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbr_we,
  input  logic [ADDR_W-1:0] dbr_base,
  input  logic [SEG_W:0]    dbr_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_segno,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [2:0]        rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata
);

  typedef enum logic [2:0] {
    S_IDLE, S_SDW0, S_SDW1, S_PTW, S_WB, S_RSP
  } state_e;

  state_e            state_q;
  logic [ADDR_W-1:0] dbr_base_q;
  logic [SEG_W:0]    dbr_len_q;
  logic              loaded_q;

  logic [OFF_W-1:0]  off_q;
  acc_kind_e         kind_q;
  logic [ADDR_W-1:0] seg_base_q;
  logic              seg_valid_q;
  logic [ADDR_W-1:0] pend_addr_q;

  logic              mem_vld_q;
  logic              mem_we_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [WORD_W-1:0] mem_wdata_q;
  logic              rsp_vld_q;
  logic [ADDR_W-1:0] rsp_addr_q;
  fault_e            rsp_fault_q;

  logic              rd_done;
  logic              req_fire;
  logic              seg_out_of_range;
  logic [ADDR_W-1:0] sdw_fetch_addr;
  sdw_attr_t         attr;
  fault_e            chk_fault;
  logic              chk_unpaged;
  logic [ADDR_W-1:0] chk_addr;
  logic              ptw_ok;
  logic [WORD_W-1:0] ptw_new;
  logic [ADDR_W-1:0] ptw_abs;

  assign req_ready        = loaded_q && (state_q == S_IDLE);
  assign req_fire         = req_valid && req_ready;
  assign rd_done          = mem_rsp_valid && !mem_vld_q;
  assign seg_out_of_range = {1'b0, req_segno} >= dbr_len_q;
  assign sdw_fetch_addr   = dbr_base_q + ADDR_W'({req_segno, 1'b0});

  assign attr.bound   = mem_rsp_rdata[SDW_BOUND_LSB +: BOUND_W];
  assign attr.rd      = mem_rsp_rdata[SDW_RD_BIT];
  assign attr.ex      = mem_rsp_rdata[SDW_EX_BIT];
  assign attr.wr      = mem_rsp_rdata[SDW_WR_BIT];
  assign attr.unpaged = mem_rsp_rdata[SDW_UNP_BIT];

  seg_xlate_sdw_chk #(
    .OFF_W (OFF_W),
    .PG_W  (PG_W),
    .BLK_W (BLK_W),
    .ADDR_W(ADDR_W)
  ) u_sdw_chk (
    .seg_base (seg_base_q),
    .seg_valid(seg_valid_q),
    .attr     (attr),
    .offset   (off_q),
    .kind     (kind_q),
    .fault    (chk_fault),
    .unpaged  (chk_unpaged),
    .next_addr(chk_addr)
  );

  seg_xlate_ptw_unit #(
    .PG_W  (PG_W),
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) u_ptw (
    .ptw     (mem_rsp_rdata),
    .pg_off  (off_q[PG_W-1:0]),
    .store   (kind_q == ACC_STORE),
    .page_ok (ptw_ok),
    .ptw_upd (ptw_new),
    .abs_addr(ptw_abs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      dbr_base_q  <= '0;
      dbr_len_q   <= '0;
      loaded_q    <= 1'b0;
      off_q       <= '0;
      kind_q      <= ACC_READ;
      seg_base_q  <= '0;
      seg_valid_q <= 1'b0;
      pend_addr_q <= '0;
      mem_vld_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      rsp_vld_q   <= 1'b0;
      rsp_addr_q  <= '0;
      rsp_fault_q <= FLT_NONE;
    end else begin
      if (dbr_we) begin
        dbr_base_q <= dbr_base;
        dbr_len_q  <= dbr_len;
        loaded_q   <= 1'b1;
      end
      if (mem_vld_q && mem_req_ready) mem_vld_q <= 1'b0;

      unique case (state_q)
        S_IDLE: begin
          if (req_fire) begin
            off_q  <= req_offset;
            kind_q <= acc_kind_e'(req_kind);
            if (seg_out_of_range) begin
              rsp_fault_q <= FLT_RANGE;
              rsp_addr_q  <= '0;
              rsp_vld_q   <= 1'b1;
              state_q     <= S_RSP;
            end else begin
              mem_addr_q <= sdw_fetch_addr;
              mem_we_q   <= 1'b0;
              mem_vld_q  <= 1'b1;
              state_q    <= S_SDW0;
            end
          end
        end
        S_SDW0: begin
          if (rd_done) begin
            seg_base_q  <= mem_rsp_rdata[SDW_ADDR_LSB +: ADDR_W];
            seg_valid_q <= mem_rsp_rdata[SDW_VALID_BIT];
            mem_addr_q  <= mem_addr_q + ADDR_W'(1);
            mem_vld_q   <= 1'b1;
            state_q     <= S_SDW1;
          end
        end
        S_SDW1: begin
          if (rd_done) begin
            if (chk_fault != FLT_NONE) begin
              rsp_fault_q <= chk_fault;
              rsp_addr_q  <= '0;
              rsp_vld_q   <= 1'b1;
              state_q     <= S_RSP;
            end else if (chk_unpaged) begin
              rsp_fault_q <= FLT_NONE;
              rsp_addr_q  <= chk_addr;
              rsp_vld_q   <= 1'b1;
              state_q     <= S_RSP;
            end else begin
              mem_addr_q <= chk_addr;
              mem_vld_q  <= 1'b1;
              state_q    <= S_PTW;
            end
          end
        end
        S_PTW: begin
          if (rd_done) begin
            if (!ptw_ok) begin
              rsp_fault_q <= FLT_PAGE;
              rsp_addr_q  <= '0;
              rsp_vld_q   <= 1'b1;
              state_q     <= S_RSP;
            end else begin
              mem_we_q    <= 1'b1;
              mem_wdata_q <= ptw_new;
              mem_vld_q   <= 1'b1;
              pend_addr_q <= ptw_abs;
              state_q     <= S_WB;
            end
          end
        end
        S_WB: begin
          if (mem_vld_q && mem_req_ready) begin
            mem_we_q    <= 1'b0;
            rsp_fault_q <= FLT_NONE;
            rsp_addr_q  <= pend_addr_q;
            rsp_vld_q   <= 1'b1;
            state_q     <= S_RSP;
          end
        end
        S_RSP: begin
          if (rsp_ready) begin
            rsp_vld_q <= 1'b0;
            state_q   <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = mem_vld_q;
  assign mem_req_we    = mem_we_q;
  assign mem_req_addr  = mem_addr_q;
  assign mem_req_wdata = mem_wdata_q;
  assign rsp_valid     = rsp_vld_q;
  assign rsp_addr      = rsp_addr_q;
  assign rsp_fault     = rsp_fault_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              dbr_we,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [2:0]        rsp_fault,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [WORD_W-1:0] mem_req_wdata
);

  logic seen_load_q;

  always_ff @(posedge clk) begin
    if (rst)         seen_load_q <= 1'b0;
    else if (dbr_we) seen_load_q <= 1'b1;
  end

  // R1: no acceptance and no memory traffic before the base register is loaded
  p_idle_until_loaded_r1: assert property (@(posedge clk) disable iff (rst)
    !seen_load_q |-> (!req_ready && !mem_req_valid));

  // R12: a pending response is held unchanged
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

  // R12: a pending memory request is held unchanged
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R12: no new request while a response is still waiting
  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R12: memory traffic and the response never overlap
  p_no_mem_during_rsp_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req_valid);

  // R13: a fault carries no address
  p_fault_no_addr_r13: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_fault != 3'd0)) |-> (rsp_addr == '0));

  // R13: only defined fault codes appear
  p_fault_code_r13: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault <= 3'd5));

  // R10: every write to memory is a page table word with its used bit set
  p_wb_used_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[PTW_USED_BIT]);

endmodule

bind seg_xlate seg_xlate_chk #(
  .ADDR_W(ADDR_W),
  .WORD_W(WORD_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dbr_we       (dbr_we),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_addr     (rsp_addr),
  .rsp_fault    (rsp_fault),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_we   (mem_req_we),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;

  localparam int SEG_W  = 12;
  localparam int OFF_W  = 18;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 36;
  localparam int unsigned AMASK = 32'h00FF_FFFF;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              dbr_we = 1'b0;
  logic [ADDR_W-1:0] dbr_base = '0;
  logic [SEG_W:0]    dbr_len = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [SEG_W-1:0]  req_segno = '0;
  logic [OFF_W-1:0]  req_offset = '0;
  logic [1:0]        req_kind = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [ADDR_W-1:0] rsp_addr;
  logic [2:0]        rsp_fault;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic              mem_req_we;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [WORD_W-1:0] mem_req_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic [WORD_W-1:0] mem_rsp_rdata = '0;

  always #10 clk = ~clk;

  seg_xlate uut (
    .clk(clk), .rst(rst),
    .dbr_we(dbr_we), .dbr_base(dbr_base), .dbr_len(dbr_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_segno(req_segno),
    .req_offset(req_offset), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit loaded = 1'b0;
  bit busy = 1'b0;
  int unsigned cur_base = 0;
  int cur_len = 0;

  logic [35:0] mem [int unsigned];
  bit          q_we [$];
  int unsigned q_addr [$];
  logic [35:0] q_dat [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [35:0] rd(input int unsigned a);
    if (mem.exists(a)) return mem[a];
    return 36'd0;
  endfunction

  function automatic logic [35:0] mk_d0(input int unsigned a, input bit v);
    return (36'(a & AMASK) << 12) | (v ? 36'd4 : 36'd0);
  endfunction

  function automatic logic [35:0] mk_d1(input int bnd, input bit r, input bit e,
                                        input bit w, input bit unp);
    return (36'(bnd) << 22) | (36'(r) << 21) | (36'(e) << 20) | (36'(w) << 19) | (36'(unp) << 17);
  endfunction

  function automatic logic [35:0] mk_pt(input int unsigned frame_abs, input bit v);
    logic [35:0] t;
    t = (36'(frame_abs / 64) << 18) | (36'(v ? 8 : 0) << 14);
    if (v) t = t | (36'd1 << 9);
    else   t = t | (36'd1 << 7);
    return t;
  endfunction

  // behavioural reference: expected result and memory traffic of one request
  function automatic void model(input int s, input int off, input int k,
                                output int flt, output int unsigned addr);
    int unsigned d, base, pa;
    logic [35:0] w0, w1, p, nw;
    bit ok;
    flt = 0; addr = 0;
    if (s >= cur_len) begin flt = 1; return; end
    d  = (cur_base + 2 * s) & AMASK;
    w0 = rd(d); w1 = rd((d + 1) & AMASK);
    q_we.push_back(1'b0); q_addr.push_back(d); q_dat.push_back('0);
    q_we.push_back(1'b0); q_addr.push_back((d + 1) & AMASK); q_dat.push_back('0);
    base = int'(w0 >> 12) & AMASK;
    case (k)
      0: ok = w1[21];
      1: ok = w1[19];
      2: ok = w1[20];
      default: ok = 1'b0;
    endcase
    if (!w0[2]) flt = 2;
    else if ((off / 16) > int'(w1 >> 22)) flt = 3;
    else if (!ok) flt = 4;
    else if (w1[17]) addr = (base + off) & AMASK;
    else begin
      pa = (base + off / 1024) & AMASK;
      q_we.push_back(1'b0); q_addr.push_back(pa); q_dat.push_back('0);
      p = rd(pa);
      if (!p[9]) flt = 5;
      else begin
        nw = p | (36'd1 << 13);
        if (k == 1) nw = nw | (36'd1 << 12);
        q_we.push_back(1'b1); q_addr.push_back(pa); q_dat.push_back(nw);
        addr = ((int'(p >> 18) & 32'h3FFFF) * 64 + off % 1024) & AMASK;
      end
    end
  endfunction

  // memory model: stalls ready, variable read latency
  logic [7:0]  lfsr = 8'hA5;
  int          rd_cnt = 0;
  logic [35:0] rd_data = '0;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = rd_data;
      end
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready = lfsr[0] | lfsr[3];
    if (!rst && mem_req_valid && mem_req_ready) begin
      if (q_addr.size() == 0) begin
        check(1'b0, "R2", "unexpected memory access", longint'(mem_req_addr), 0);
      end else begin
        check(mem_req_we == q_we[0], q_we[0] ? "R10" : "R3", "access direction",
              longint'(mem_req_we), longint'(q_we[0]));
        check(mem_req_addr == q_addr[0][23:0], q_we[0] ? "R10" : "R8", "access address",
              longint'(mem_req_addr), longint'(q_addr[0]));
        if (q_we[0])
          check(mem_req_wdata == q_dat[0], "R10", "write-back word",
                longint'(mem_req_wdata), longint'(q_dat[0]));
        void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_dat.pop_front());
      end
      if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
      else begin
        rd_data = rd(mem_req_addr);
        rd_cnt  = 1 + int'(lfsr[1]);
      end
    end
  end

  // per-clock comparison against the model's handshake state
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      check(req_ready == (loaded && !busy), loaded ? "R12" : "R1", "req_ready",
            longint'(req_ready), longint'(loaded && !busy));
      if (!busy) begin
        check(!rsp_valid, "R12", "response with nothing outstanding", longint'(rsp_valid), 0);
        check(!mem_req_valid, "R1", "memory request while idle", longint'(mem_req_valid), 0);
      end
    end
  end

  task automatic load_dbr(input int unsigned base, input int len);
    @(negedge clk);
    dbr_we = 1'b1; dbr_base = base[23:0]; dbr_len = 13'(len);
    cur_base = base; cur_len = len; loaded = 1'b1;
    @(negedge clk);
    dbr_we = 1'b0;
  endtask

  task automatic do_req(input int s, input int off, input int k, input int hold,
                        input string tag);
    int ef;
    int unsigned ea;
    @(negedge clk);
    req_valid = 1'b1; req_segno = 12'(s); req_offset = 18'(off); req_kind = 2'(k);
    while (!req_ready) @(negedge clk);
    model(s, off, k, ef, ea);
    busy = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (hold) @(negedge clk);
    rsp_ready = 1'b1;
    while (!rsp_valid) @(negedge clk);
    check(rsp_fault == 3'(ef), tag, "fault code", longint'(rsp_fault), longint'(ef));
    if (ef == 0)
      check(rsp_addr == ea[23:0], tag, "absolute address", longint'(rsp_addr), longint'(ea));
    else
      check(rsp_addr == '0, "R13", "address on fault", longint'(rsp_addr), 0);
    check(q_addr.size() == 0, (ef == 5) ? "R9" : "R10", "accesses left undone",
          longint'(q_addr.size()), 0);
    q_we.delete(); q_addr.delete(); q_dat.delete();
    busy = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // descriptor array at 0x1000, eight entries
    mem[32'h1000] = mk_d0(32'h20000, 1); mem[32'h1001] = mk_d1(10, 1, 0, 1, 1);
    mem[32'h1002] = mk_d0(32'h3000, 1);  mem[32'h1003] = mk_d1(200, 1, 1, 1, 0);
    mem[32'h1004] = mk_d0(32'h7000, 0);  mem[32'h1005] = mk_d1(50, 1, 1, 1, 1);
    mem[32'h1006] = mk_d0(32'h9000, 1);  mem[32'h1007] = mk_d1(0, 0, 1, 0, 1);
    mem[32'h1008] = mk_d0(32'hA000, 0);  mem[32'h1009] = mk_d1(0, 0, 0, 0, 1);
    mem[32'h100A] = mk_d0(32'hB000, 1);  mem[32'h100B] = mk_d1(0, 1, 0, 0, 1);
    mem[32'h100C] = mk_d0(32'h3200, 1);  mem[32'h100D] = mk_d1(100, 1, 0, 0, 0);
    mem[32'h100E] = mk_d0(32'h3100, 1);  mem[32'h100F] = mk_d1(63, 1, 1, 1, 0);
    // page tables
    mem[32'h3000] = mk_pt(32'h5000, 1);
    mem[32'h3001] = mk_pt(0, 0);
    mem[32'h3002] = mk_pt(32'h8000, 1);
    mem[32'h3100] = mk_pt(32'hFFFC00, 1);
    mem[32'h3200] = mk_pt(0, 0);
    // last descriptor of a full-size array at 0x40000
    mem[32'h41FFE] = mk_d0(32'hFFFFF0, 1); mem[32'h41FFF] = mk_d1(16383, 1, 1, 1, 1);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: a request before loading is never taken
    req_valid = 1'b1; req_segno = 12'd0;
    repeat (6) @(negedge clk);
    check(!req_ready && !mem_req_valid && !rsp_valid, "R1", "idle before load",
          longint'({req_ready, mem_req_valid, rsp_valid}), 0);
    req_valid = 1'b0;

    load_dbr(32'h1000, 8);
    do_req(0, 0, 0, 0, "R7");
    do_req(0, 175, 1, 2, "R7");      // last word inside the bound
    do_req(0, 176, 0, 0, "R5");      // first block past the bound
    do_req(0, 5, 2, 1, "R6");        // no execute right
    do_req(1, 5, 0, 0, "R8");        // paged read, used bit
    do_req(1, 32'h410, 1, 0, "R9");  // non-resident page
    do_req(1, 32'hBFF, 1, 3, "R10"); // store sets modified bit
    do_req(1, 7, 2, 0, "R8");        // fetch after earlier write-back
    do_req(1, 3216, 0, 0, "R5");     // block 201 of bound 200
    do_req(2, 0, 0, 0, "R4");
    do_req(3, 15, 2, 0, "R6");
    do_req(3, 16, 2, 0, "R5");
    do_req(3, 0, 0, 0, "R6");
    do_req(4, 100, 3, 0, "R11");     // invalid wins over bound and access
    do_req(5, 40, 1, 0, "R11");      // bound wins over access
    do_req(6, 0, 1, 0, "R11");       // access wins over page
    do_req(6, 0, 0, 0, "R9");
    do_req(7, 32'h3FF, 0, 1, "R8");  // top of memory
    do_req(7, 0, 3, 0, "R6");        // reserved kind
    do_req(8, 0, 0, 0, "R2");
    do_req(4095, 0, 0, 2, "R2");

    load_dbr(32'h40000, 4096);
    do_req(4095, 32'h20, 1, 0, "R7");  // address wraps modulo 2^24
    do_req(4094, 0, 0, 0, "R4");
    do_req(0, 0, 0, 0, "R4");
    load_dbr(32'h1000, 0);
    do_req(0, 0, 0, 0, "R2");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule